// File: doc/BRIEF.md
# NAND Power-Up Initialization Sequencer

This block runs exactly once after the flash controller leaves reset. It walks an attached 8-bit NAND device through discovery, device reset and boot-page preparation by issuing commands to a separate command engine. Each command is a one-cycle request that carries an opcode, an address and a byte count. The sequencer then waits for a done pulse from the engine. Bytes that the device returns during the command arrive on a valid/data stream and are captured inside the sequencer.

Discovery reads four ID bytes from address 0x20 and compares them with the ASCII characters "ONFI". A full match sends the sequencer down the parameter-page path. Any mismatch sends it down the legacy path, which resets the device and then reads its ID bytes. In both cases the captured bytes appear on `dev_info_o`. Two of the four bootstrap bits, latched at reset release, can shorten the run. One skips discovery entirely. The other skips only the block 0 / page 0 load. The run always ends with a device reset, after which a sticky reset-complete flag is raised.

Top module: `nand_init_seq`

## Requirements
- R1: `boot_cfg_i` is captured on the first clock edge after `rst_ni` is released and is shown on `boot_cfg_o`. Later changes to `boot_cfg_i` have no effect until the next reset.
- R2: If latched bit 0 (inhibit init) is set, the only command issued is a single device reset. After it completes, the reset-complete flag is set.
- R3: `cmd_op_o` encodes 0 = read ID, 1 = read parameter page, 2 = reset, 3 = page load. Discovery starts only once `dev_rdy_i` is high. Its first command is read ID with address 0x20 and length 4.
- R4: If the four returned signature bytes are 0x4F, 0x4E, 0x46, 0x49 in order, the next command is read parameter page (address 0, length INFO_BYTES). The returned bytes appear on `dev_info_o`, with byte k at bits [8k+7:8k], and `onfi_o` is 1.
- R5: If any signature byte differs, the next commands are reset, then read ID (address 0, length INFO_BYTES). Those bytes are captured on `dev_info_o`, and `onfi_o` is 0.
- R6: After either discovery path a reset command is issued. Once it completes, `io_width_o` reads 8. Before that it reads 0.
- R7: A page-load command (address 0) follows the width-check reset, unless latched bit 1 (inhibit boot-page load) is set.
- R8: The last command is a reset. When it completes, `rst_comp_o` rises and `busy_o` falls in the same cycle.
- R9: `busy_o` is high from reset until completion. `rst_comp_o` stays high until `rst_comp_clr_i` is pulsed, which clears it.
- R10: `cmd_req_o` is a one-cycle pulse. No further request is issued before `cmd_done_i`, and after done the next request waits for `dev_rdy_i`.
- R11: Latched bits 3:2 do not change the command sequence. They only appear on `boot_cfg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_cfg_i | input | 4 | Bootstrap control bits (0: skip init, 1: skip boot-page load) |
| boot_cfg_o | output | 4 | Bootstrap bits as latched at reset release |
| dev_rdy_i | input | 1 | Device ready |
| cmd_req_o | output | 1 | Command request pulse |
| cmd_op_o | output | 2 | Command opcode |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_len_o | output | LEN_W | Number of bytes to return |
| cmd_done_i | input | 1 | Command completion pulse |
| rd_valid_i | input | 1 | Returned byte valid |
| rd_data_i | input | 8 | Returned byte |
| dev_info_o | output | 8*INFO_BYTES | Captured device feature bytes |
| onfi_o | output | 1 | Device identified as ONFI |
| io_width_o | output | 4 | Detected interface width |
| busy_o | output | 1 | Initialization in progress |
| rst_comp_o | output | 1 | Reset-complete flag |
| rst_comp_clr_i | input | 1 | Write-one-to-clear for the flag |

## Verification
The hardest case to reach is a signature that differs from "ONFI" in only its last byte. The legacy path should be taken, but a compare that checks fewer than four bytes would still take the ONFI path. The bench's device model returns a programmable signature, with only the final byte altered. A second hard case is a change of the bootstrap inputs right after reset release. Here the bench flips `boot_cfg_i` two cycles after release and confirms from the command log and `boot_cfg_o` that the change had no effect.

// File: rtl/nand_init_pkg.sv
package nand_init_pkg;
  typedef enum logic [1:0] {
    OP_READ_ID    = 2'd0,
    OP_READ_PARAM = 2'd1,
    OP_RESET      = 2'd2,
    OP_PAGE_LOAD  = 2'd3
  } nand_op_e;

  typedef enum logic [3:0] {
    ST_START, ST_PROBE, ST_PARAM, ST_LEG_RST, ST_LEG_ID,
    ST_MID_RST, ST_B0P0, ST_FIN_RST, ST_DONE
  } step_e;

  typedef enum logic [1:0] {PH_RDY, PH_REQ, PH_WAIT} phase_e;

  typedef enum logic [1:0] {DST_NONE, DST_SIG, DST_INFO} cap_dst_e;

  localparam int CFG_W         = 4;
  localparam int CFG_INH_INIT  = 0;
  localparam int CFG_INH_LOAD  = 1;
  localparam int SIG_BYTES     = 4;
  localparam int DEV_WIDTH     = 8;

  function automatic logic [7:0] sig_char(input int idx);
    case (idx)
      0:       return 8'h4F;
      1:       return 8'h4E;
      2:       return 8'h46;
      default: return 8'h49;
    endcase
  endfunction
endpackage

// File: rtl/nand_init_cfg.sv
module nand_init_cfg
  import nand_init_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cfg_eff_o,
  output logic [CFG_W-1:0] cfg_q_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      taken_q <= 1'b0;
    end else if (!taken_q) begin
      cfg_q   <= cfg_i;
      taken_q <= 1'b1;
    end
  end

  // live value only in the capture cycle itself
  assign cfg_eff_o = taken_q ? cfg_q : cfg_i;
  assign cfg_q_o   = cfg_q;
endmodule

// File: rtl/nand_init_capture.sv
module nand_init_capture
  import nand_init_pkg::*;
#(
  parameter int INFO_BYTES = 4,
  localparam int MAX_B     = (INFO_BYTES > SIG_BYTES) ? INFO_BYTES : SIG_BYTES,
  localparam int CNT_W     = $clog2(MAX_B) + 1,
  localparam int IDX_W     = (INFO_BYTES > 1) ? $clog2(INFO_BYTES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    active_i,
  input  cap_dst_e                dst_i,
  input  logic                    rd_valid_i,
  input  logic [7:0]              rd_data_i,
  output logic                    sig_ok_o,
  output logic [8*INFO_BYTES-1:0] info_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sig_q  [SIG_BYTES];
  logic [7:0]       info_q [INFO_BYTES];
  logic [SIG_BYTES-1:0] match;
  logic             take;

  assign take = active_i && rd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (take && cnt_q != {CNT_W{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SIG_BYTES; i++) sig_q[i] <= '0;
    end else if (take && dst_i == DST_SIG && cnt_q < CNT_W'(SIG_BYTES)) begin
      sig_q[cnt_q[1:0]] <= rd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < INFO_BYTES; i++) info_q[i] <= '0;
    end else if (take && dst_i == DST_INFO && cnt_q < CNT_W'(INFO_BYTES)) begin
      info_q[cnt_q[IDX_W-1:0]] <= rd_data_i;
    end
  end

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
    assign match[g] = (sig_q[g] == sig_char(g));
  end

  for (genvar g = 0; g < INFO_BYTES; g++) begin : g_info
    assign info_o[8*g +: 8] = info_q[g];
  end

  assign sig_ok_o = &match;
endmodule

// File: rtl/nand_init_fsm.sv
module nand_init_fsm
  import nand_init_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          LEN_W      = 8,
  parameter int          INFO_BYTES = 4,
  parameter logic [ADDR_W-1:0] SIG_ADDR = ADDR_W'(8'h20)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inh_init_i,
  input  logic              inh_load_i,
  input  logic              dev_rdy_i,
  input  logic              cmd_done_i,
  input  logic              sig_ok_i,
  output logic              cmd_req_o,
  output nand_op_e          cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output cap_dst_e          cap_dst_o,
  output logic              cap_active_o,
  output logic              probe_done_o,
  output logic              width_done_o,
  output logic              final_done_o,
  output logic              busy_o
);
  step_e  step_q, step_d, step_nx;
  phase_e phase_q, phase_d;
  logic   step_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_START;
      phase_q <= PH_RDY;
    end else begin
      step_q  <= step_d;
      phase_q <= phase_d;
    end
  end

  assign step_done = (phase_q == PH_WAIT) && cmd_done_i;

  always_comb begin
    case (step_q)
      ST_PROBE:   step_nx = sig_ok_i ? ST_PARAM : ST_LEG_RST;
      ST_PARAM:   step_nx = ST_MID_RST;
      ST_LEG_RST: step_nx = ST_LEG_ID;
      ST_LEG_ID:  step_nx = ST_MID_RST;
      ST_MID_RST: step_nx = inh_load_i ? ST_FIN_RST : ST_B0P0;
      ST_B0P0:    step_nx = ST_FIN_RST;
      default:    step_nx = ST_DONE;
    endcase
  end

  always_comb begin
    step_d  = step_q;
    phase_d = phase_q;
    case (phase_q)
      PH_RDY: begin
        if (step_q == ST_START) begin
          step_d = inh_init_i ? ST_FIN_RST : ST_PROBE;
        end else if (step_q != ST_DONE && dev_rdy_i) begin
          phase_d = PH_REQ;
        end
      end
      PH_REQ: phase_d = PH_WAIT;
      PH_WAIT: begin
        if (cmd_done_i) begin
          phase_d = PH_RDY;
          step_d  = step_nx;
        end
      end
      default: phase_d = PH_RDY;
    endcase
  end

  always_comb begin
    cmd_op_o   = OP_RESET;
    cmd_addr_o = '0;
    cmd_len_o  = '0;
    cap_dst_o  = DST_NONE;
    case (step_q)
      ST_PROBE: begin
        cmd_op_o   = OP_READ_ID;
        cmd_addr_o = SIG_ADDR;
        cmd_len_o  = LEN_W'(SIG_BYTES);
        cap_dst_o  = DST_SIG;
      end
      ST_PARAM: begin
        cmd_op_o  = OP_READ_PARAM;
        cmd_len_o = LEN_W'(INFO_BYTES);
        cap_dst_o = DST_INFO;
      end
      ST_LEG_ID: begin
        cmd_op_o  = OP_READ_ID;
        cmd_len_o = LEN_W'(INFO_BYTES);
        cap_dst_o = DST_INFO;
      end
      ST_B0P0: cmd_op_o = OP_PAGE_LOAD;
      default: cmd_op_o = OP_RESET;
    endcase
  end

  assign cmd_req_o    = (phase_q == PH_REQ);
  assign cap_active_o = (phase_q == PH_WAIT);
  assign probe_done_o = step_done && step_q == ST_PROBE;
  assign width_done_o = step_done && step_q == ST_MID_RST;
  assign final_done_o = step_done && step_q == ST_FIN_RST;
  assign busy_o       = (step_q != ST_DONE);
endmodule

// File: rtl/nand_init_seq.sv
module nand_init_seq
  import nand_init_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 8,
  parameter int INFO_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [3:0]              boot_cfg_i,
  output logic [3:0]              boot_cfg_o,
  input  logic                    dev_rdy_i,
  output logic                    cmd_req_o,
  output logic [1:0]              cmd_op_o,
  output logic [ADDR_W-1:0]       cmd_addr_o,
  output logic [LEN_W-1:0]        cmd_len_o,
  input  logic                    cmd_done_i,
  input  logic                    rd_valid_i,
  input  logic [7:0]              rd_data_i,
  output logic [8*INFO_BYTES-1:0] dev_info_o,
  output logic                    onfi_o,
  output logic [3:0]              io_width_o,
  output logic                    busy_o,
  output logic                    rst_comp_o,
  input  logic                    rst_comp_clr_i
);
  logic [CFG_W-1:0] cfg_eff, cfg_q;
  nand_op_e         op;
  cap_dst_e         cap_dst;
  logic             cap_active, sig_ok;
  logic             probe_done, width_done, final_done;
  logic             onfi_q, rst_comp_q;
  logic [3:0]       width_q;

  nand_init_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (boot_cfg_i),
    .cfg_eff_o (cfg_eff),
    .cfg_q_o   (cfg_q)
  );

  nand_init_fsm #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .INFO_BYTES (INFO_BYTES)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inh_init_i   (cfg_eff[CFG_INH_INIT]),
    .inh_load_i   (cfg_eff[CFG_INH_LOAD]),
    .dev_rdy_i    (dev_rdy_i),
    .cmd_done_i   (cmd_done_i),
    .sig_ok_i     (sig_ok),
    .cmd_req_o    (cmd_req_o),
    .cmd_op_o     (op),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_len_o    (cmd_len_o),
    .cap_dst_o    (cap_dst),
    .cap_active_o (cap_active),
    .probe_done_o (probe_done),
    .width_done_o (width_done),
    .final_done_o (final_done),
    .busy_o       (busy_o)
  );

  nand_init_capture #(
    .INFO_BYTES (INFO_BYTES)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cmd_req_o),
    .active_i   (cap_active),
    .dst_i      (cap_dst),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .sig_ok_o   (sig_ok),
    .info_o     (dev_info_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      onfi_q     <= 1'b0;
      width_q    <= '0;
      rst_comp_q <= 1'b0;
    end else begin
      if (probe_done) onfi_q <= sig_ok;
      // only an 8-bit bus exists, so the check always resolves to 8
      if (width_done) width_q <= 4'(DEV_WIDTH);
      if (final_done)          rst_comp_q <= 1'b1;
      else if (rst_comp_clr_i) rst_comp_q <= 1'b0;
    end
  end

  assign cmd_op_o   = op;
  assign boot_cfg_o = cfg_q;
  assign onfi_o     = onfi_q;
  assign io_width_o = width_q;
  assign rst_comp_o = rst_comp_q;
endmodule

// File: rtl/nand_init_seq_chk.sv
module nand_init_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] boot_cfg_i,
  input logic [3:0] boot_cfg_o,
  input logic       dev_rdy_i,
  input logic       cmd_req_o,
  input logic       cmd_done_i,
  input logic [3:0] io_width_o,
  input logic       busy_o,
  input logic       rst_comp_o,
  input logic       rst_comp_clr_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !cmd_req_o); // R10
  AST_REQ_AFTER_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_req_o) |-> $past(dev_rdy_i)); // R3
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> $stable(boot_cfg_o)); // R1
  AST_WIDTH_EIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_width_o != 4'd0 |-> io_width_o == 4'd8); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_comp_o |-> !busy_o); // R8
  AST_FLAG_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_comp_o) |-> $past(cmd_done_i)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_comp_o && !rst_comp_clr_i |=> rst_comp_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_req_o); // R9

  logic unused_cfg;
  assign unused_cfg = ^boot_cfg_i;
endmodule

bind nand_init_seq nand_init_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .boot_cfg_i     (boot_cfg_i),
  .boot_cfg_o     (boot_cfg_o),
  .dev_rdy_i      (dev_rdy_i),
  .cmd_req_o      (cmd_req_o),
  .cmd_done_i     (cmd_done_i),
  .io_width_o     (io_width_o),
  .busy_o         (busy_o),
  .rst_comp_o     (rst_comp_o),
  .rst_comp_clr_i (rst_comp_clr_i)
);

// File: tb/nand_init_seq_bench.sv
module nand_init_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  boot_cfg = 4'd0;
  logic [3:0]  boot_cfg_o;
  logic        dev_rdy;
  logic        cmd_req;
  logic [1:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [7:0]  cmd_len;
  logic        cmd_done = 1'b0;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'd0;
  logic [31:0] dev_info;
  logic        onfi;
  logic [3:0]  io_width;
  logic        busy;
  logic        rst_comp;
  logic        clr = 1'b0;

  logic m_rdy = 1'b1;
  logic t_rdy = 1'b1;
  assign dev_rdy = m_rdy & t_rdy;

  int n_chk = 0, n_fail = 0;
  int n_log = 0, pulse_err = 0;
  int log_op [16], log_addr [16], log_len [16];
  int exp_op [8], exp_addr [8], exp_len [8];
  logic [7:0] sig_b [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_init_seq u_nand_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .boot_cfg_i(boot_cfg), .boot_cfg_o(boot_cfg_o),
    .dev_rdy_i(dev_rdy), .cmd_req_o(cmd_req), .cmd_op_o(cmd_op),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len), .cmd_done_i(cmd_done),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .dev_info_o(dev_info),
    .onfi_o(onfi), .io_width_o(io_width), .busy_o(busy),
    .rst_comp_o(rst_comp), .rst_comp_clr_i(clr)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int op, input int addr, input int k);
    if (op == 0 && addr == 32) return sig_b[k % 4];
    if (op == 0) return 8'hB0 + 8'(k);
    return 8'hA0 + 8'(k);
  endfunction

  // device / command engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && cmd_req) begin
        int op, addr, len;
        op = int'(cmd_op); addr = int'(cmd_addr); len = int'(cmd_len);
        if (n_log < 16) begin
          log_op[n_log] = op; log_addr[n_log] = addr; log_len[n_log] = len;
        end
        n_log++;
        m_rdy = 1'b0;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          if (cmd_req) pulse_err++;
        end
        for (int k = 0; k < len; k++) begin
          rd_valid = 1'b1; rd_data = resp(op, addr, k);
          @(negedge clk);
          if (cmd_req) pulse_err++;
        end
        rd_valid = 1'b0;
        cmd_done = 1'b1;
        @(negedge clk);
        if (cmd_req) pulse_err++;
        cmd_done = 1'b0;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          if (cmd_req) pulse_err++;
        end
        m_rdy = 1'b1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic set_sig(input logic [7:0] last);
    sig_b[0] = 8'h4F; sig_b[1] = 8'h4E; sig_b[2] = 8'h46; sig_b[3] = last;
  endtask

  task automatic start(input logic [3:0] cfg);
    rst_ni = 1'b0; boot_cfg = cfg;
    repeat (3) @(negedge clk);
    n_log = 0; pulse_err = 0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!rst_comp && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(req, "completion", rst_comp, 1);
    chk(req, "busy low", busy, 0);
    chk("R10", "pulse/overlap errors", pulse_err, 0);
  endtask

  task automatic set_exp(input int i, input int op, input int addr, input int len);
    exp_op[i] = op; exp_addr[i] = addr; exp_len[i] = len;
  endtask

  task automatic chk_seq(input string req, input int n);
    chk(req, "command count", n_log, n);
    for (int i = 0; i < n && i < n_log; i++) begin
      chk(req, $sformatf("cmd%0d op", i), log_op[i], exp_op[i]);
      chk(req, $sformatf("cmd%0d addr", i), log_addr[i], exp_addr[i]);
      chk(req, $sformatf("cmd%0d len", i), log_len[i], exp_len[i]);
    end
  endtask

  task automatic exp_onfi_full();
    set_exp(0, 0, 32, 4); set_exp(1, 1, 0, 4); set_exp(2, 2, 0, 0);
    set_exp(3, 3, 0, 0);  set_exp(4, 2, 0, 0);
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "busy in reset", busy, 1);
    chk("R9", "flag in reset", rst_comp, 0);
    chk("R10", "req in reset", cmd_req, 0);
    chk("R6", "width in reset", io_width, 0);
  endtask

  task automatic t_onfi_path();
    set_sig(8'h49);
    start(4'b0000);
    @(negedge clk); @(negedge clk);
    chk("R6", "width before reset step", io_width, 0);
    wait_done("R8");
    exp_onfi_full();
    chk_seq("R4", 5);
    chk("R4", "onfi flag", onfi, 1);
    chk("R4", "param bytes", dev_info, 32'hA3A2A1A0);
    chk("R6", "width", io_width, 8);
    chk("R7", "page load present", log_op[3], 3);
  endtask

  task automatic t_legacy_path();
    set_sig(8'h48);  // only the last byte is wrong
    start(4'b0000);
    wait_done("R8");
    set_exp(0, 0, 32, 4); set_exp(1, 2, 0, 0); set_exp(2, 0, 0, 4);
    set_exp(3, 2, 0, 0);  set_exp(4, 3, 0, 0); set_exp(5, 2, 0, 0);
    chk_seq("R5", 6);
    chk("R5", "onfi flag", onfi, 0);
    chk("R5", "id bytes", dev_info, 32'hB3B2B1B0);
    chk("R6", "width", io_width, 8);
  endtask

  task automatic t_inhibit_init();
    set_sig(8'h49);
    start(4'b0001);
    @(negedge clk); @(negedge clk);
    boot_cfg = 4'b0000;
    wait_done("R2");
    set_exp(0, 2, 0, 0);
    chk_seq("R2", 1);
    chk("R2", "width untouched", io_width, 0);
    chk("R1", "latched cfg", boot_cfg_o, 4'b0001);
  endtask

  task automatic t_inhibit_load();
    set_sig(8'h49);
    start(4'b0010);
    wait_done("R7");
    set_exp(0, 0, 32, 4); set_exp(1, 1, 0, 4); set_exp(2, 2, 0, 0); set_exp(3, 2, 0, 0);
    chk_seq("R7", 4);
  endtask

  task automatic t_cfg_change();
    set_sig(8'h49);
    start(4'b0010);
    @(negedge clk); @(negedge clk);
    boot_cfg = 4'b0001;
    wait_done("R1");
    set_exp(0, 0, 32, 4); set_exp(1, 1, 0, 4); set_exp(2, 2, 0, 0); set_exp(3, 2, 0, 0);
    chk_seq("R1", 4);
    chk("R1", "latched cfg", boot_cfg_o, 4'b0010);
  endtask

  task automatic t_reserved_bits();
    set_sig(8'h49);
    start(4'b1100);
    wait_done("R11");
    exp_onfi_full();
    chk_seq("R11", 5);
    chk("R11", "latched cfg", boot_cfg_o, 4'b1100);
  endtask

  task automatic t_ready_gate();
    set_sig(8'h49);
    t_rdy = 1'b0;
    start(4'b0000);
    repeat (20) @(negedge clk);
    chk("R3", "no command while not ready", n_log, 0);
    chk("R9", "busy while waiting", busy, 1);
    t_rdy = 1'b1;
    wait_done("R3");
    chk("R3", "first op", log_op[0], 0);
    chk("R3", "first addr", log_addr[0], 32);
  endtask

  task automatic t_flag_clear();
    repeat (5) @(negedge clk);
    chk("R9", "flag sticky", rst_comp, 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "flag cleared", rst_comp, 0);
    chk("R9", "busy stays low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R10", "no command after done", cmd_req, 0);
  endtask

  initial begin
    t_reset_state();
    t_onfi_path();
    t_flag_clear();
    t_legacy_path();
    t_inhibit_init();
    t_inhibit_load();
    t_cfg_change();
    t_reserved_bits();
    t_ready_gate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule